// File: doc/BRIEF.md
# Multiply-Accumulate Accumulator Saturation and Flag Unit

This block keeps the accumulator state of a multiply-accumulate engine: a small bank of accumulators, each 48 bits of value plus 16 guard bits held in one 64-bit word, and a status word. The low bits of the status word select the operating mode: round, signed, fractional and overflow clamping. The upper bits are sticky condition flags, including one "accumulator overflowed" bit for each accumulator. Three kinds of command act on a chosen accumulator. A saturate command checks the accumulator against a signed, unsigned or fractional range and clamps or trims it. A flag-update command folds that accumulator's zero, negative, overflow and guard-bit conditions into the sticky flags. A move command copies one accumulator into another.

A command is a one-cycle strobe. Its accumulator and status results are registered at that clock edge. A host register port writes and reads accumulators and the status word. Reads return one cycle after the select is presented. The multiplier, instruction decoding and packing of guard bits into host words are handled elsewhere.

Top module: `mac_acc_sat`

## Requirements
- R1: A synchronous active-high reset clears every accumulator, the status word, `status_o` and `reg_rdata` to zero.
- R2: `reg_sel` values 0 to 3 address accumulators 0 to 3, and value 4 addresses the status word. A write with `reg_we` takes effect at the clock edge. `reg_rdata` presents, one clock after a select, the addressed item as it stood before that edge. The status word is zero-extended. Its bits are: 0 round, 1 signed mode, 2 fractional mode, 3 clamp enable, 4 overflow (V), 5 zero (Z), 6 negative (N), 7 guard-bit overflow (EV), and 8+i the overflow bit of accumulator i.
- R3: The signed saturate (`cmd_op` 0) raises V when the accumulator differs from the sign extension of its low 48 bits. Without clamping, the accumulator becomes that sign extension.
- R4: With clamp enable set, a signed saturate that ends with V set writes 0x000000007fffffff when bit 47 is clear. It writes 0xffffffff80000000 when bit 47 is set.
- R5: The unsigned saturate (`cmd_op` 1) raises V when any of bits 63..48 is set. With V set and clamping on, the result is 0 if the value exceeds 2^53 and 2^48-1 otherwise. With V set and clamping off, the value is masked to 48 bits.
- R6: The fractional saturate (`cmd_op` 2) detects overflow like the signed one. With clamping on it writes 0x00007fffffffffff when bit 47 is clear and 0xffff800000000000 when bit 47 is set.
- R7: Whenever V is set after a saturate, including V already held from earlier, the target accumulator's overflow bit is set. The clamp then applies even to an in-range value.
- R8: The flag update (`cmd_op` 3) sets Z when the full 64-bit accumulator is zero, otherwise sets N when bit 47 is set. It sets V when that accumulator's overflow bit is set. The accumulator is left unchanged.
- R9: The flag update sets EV as follows. In fractional mode, when bits 63..40 are not all equal. Otherwise in signed mode, when bits 63..32 are not all equal. In unsigned mode, when any of bits 63..32 is set.
- R10: A move (`cmd_op` 4) copies accumulator `cmd_src` into accumulator `cmd_acc`, and copies the source's overflow bit into the destination's overflow bit, which may clear it.
- R11: V, Z, N, EV and the per-accumulator overflow bits only accumulate. Only a status write changes them otherwise, and it replaces the whole status word.
- R12: When a command and a host write land in the same cycle, the command's accumulator result wins over a host write to the same accumulator. A status write forms the new base, the command's raised flags are ORed into it, and the command follows the mode bits held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command code: 0 signed, 1 unsigned, 2 fractional saturate, 3 flag update, 4 move |
| cmd_acc | input | 2 | Target accumulator (destination of a move) |
| cmd_src | input | 2 | Source accumulator of a move |
| reg_we | input | 1 | Host write enable |
| reg_sel | input | 3 | Host select: 0-3 accumulator, 4 status |
| reg_wdata | input | 64 | Host write data |
| reg_rdata | output | 64 | Registered host read data |
| status_o | output | 12 | Current status word |

## Verification
A command and a host-port write can fall in the same clock edge and compete for the same state. The bench provokes this twice. First, an unsigned saturate targets an accumulator that the host writes in the same cycle, and the read-back must show the command's result built from the old value. Second, a flag update is issued together with a status write that changes the mode. The resulting status must equal the written word plus exactly the flags that the old mode produces, which differ from those the new mode would produce.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;

  typedef enum logic [2:0] {
    OP_SAT_S  = 3'd0,
    OP_SAT_U  = 3'd1,
    OP_SAT_F  = 3'd2,
    OP_FLAGS  = 3'd3,
    OP_MOVE   = 3'd4
  } mac_op_e;

  typedef enum logic [1:0] {
    SK_SIGNED   = 2'd0,
    SK_UNSIGNED = 2'd1,
    SK_FRAC     = 2'd2,
    SK_NONE     = 2'd3
  } sat_kind_e;

  // status word layout
  localparam int ST_RND  = 0;
  localparam int ST_SGN  = 1;
  localparam int ST_FRAC = 2;
  localparam int ST_OMC  = 3;
  localparam int ST_V    = 4;
  localparam int ST_Z    = 5;
  localparam int ST_N    = 6;
  localparam int ST_EV   = 7;
  localparam int ST_PAV  = 8;

endpackage

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_sat_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ACC_W  = 48
) (
  input  logic [DATA_W-1:0] val,
  input  sat_kind_e         kind,
  input  logic              clamp_en,
  input  logic              v_prev,
  output logic [DATA_W-1:0] res,
  output logic              ovf,
  output logic              v_any
);
  localparam int               GUARD_W  = DATA_W - ACC_W;
  localparam logic [DATA_W-1:0] ONE     = 1;
  localparam logic [DATA_W-1:0] POS_W32 = {{(DATA_W-31){1'b0}}, {31{1'b1}}};
  localparam logic [DATA_W-1:0] POS_ACC = {{(GUARD_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] U_MAX   = {{GUARD_W{1'b0}}, {ACC_W{1'b1}}};
  localparam logic [DATA_W-1:0] U_LIMIT = ONE << (ACC_W + 5);

  logic [DATA_W-1:0] sx;
  logic [DATA_W-1:0] masked;

  assign sx     = {{GUARD_W{val[ACC_W-1]}}, val[ACC_W-1:0]};
  assign masked = {{GUARD_W{1'b0}}, val[ACC_W-1:0]};

  always_comb begin
    ovf = 1'b0;
    case (kind)
      SK_SIGNED, SK_FRAC: ovf = (sx != val);
      SK_UNSIGNED:        ovf = |val[DATA_W-1:ACC_W];
      default:            ovf = 1'b0;
    endcase
    v_any = ovf | v_prev;

    res = val;
    case (kind)
      SK_SIGNED: begin
        if (v_any && clamp_en) res = sx[ACC_W-1] ? ~POS_W32 : POS_W32;
        else                   res = sx;
      end
      SK_FRAC: begin
        if (v_any && clamp_en) res = sx[ACC_W-1] ? ~POS_ACC : POS_ACC;
        else                   res = sx;
      end
      SK_UNSIGNED: begin
        if (v_any) begin
          if (clamp_en) res = (val > U_LIMIT) ? '0 : U_MAX;
          else          res = masked;
        end
      end
      default: res = val;
    endcase
  end
endmodule

// File: rtl/mac_flag_eval.sv
module mac_flag_eval #(
  parameter int DATA_W   = 64,
  parameter int ACC_W    = 48,
  parameter int FRAC_TOP = 40,
  parameter int INT_TOP  = 32
) (
  input  logic [DATA_W-1:0] val,
  input  logic              frac_mode,
  input  logic              sgn_mode,
  input  logic              pav,
  output logic              z,
  output logic              n,
  output logic              v,
  output logic              ev
);
  logic [DATA_W-FRAC_TOP-1:0] hi_f;
  logic [DATA_W-INT_TOP-1:0]  hi_i;
  logic                       flat_f, flat_i;

  assign hi_f   = val[DATA_W-1:FRAC_TOP];
  assign hi_i   = val[DATA_W-1:INT_TOP];
  assign flat_f = (&hi_f) | ~(|hi_f);
  assign flat_i = (&hi_i) | ~(|hi_i);

  always_comb begin
    z = (val == '0);
    n = !z && val[ACC_W-1];
    v = pav;
    if (frac_mode)     ev = !flat_f;
    else if (sgn_mode) ev = !flat_i;
    else               ev = |hi_i;
  end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
  parameter int NUM_ACC = 4,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              host_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic [IDX_W-1:0]  rd_c_idx,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [DATA_W-1:0] rd_c
);
  logic [DATA_W-1:0] mem [NUM_ACC];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ACC; i++) mem[i] <= '0;
    end else begin
      if (host_we) mem[host_idx] <= host_wdata;
      if (cmd_we)  mem[cmd_idx]  <= cmd_wdata;   // command wins on a clash
    end
  end

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];
  assign rd_c = mem[rd_c_idx];
endmodule

// File: rtl/mac_acc_sat.sv
module mac_acc_sat
  import mac_sat_pkg::*;
#(
  parameter int NUM_ACC  = 4,
  parameter int DATA_W   = 64,
  parameter int ACC_W    = 48,
  parameter int FRAC_TOP = 40,
  parameter int INT_TOP  = 32,
  parameter int IDX_W    = $clog2(NUM_ACC),
  parameter int SEL_W    = $clog2(NUM_ACC + 1),
  parameter int ST_W     = ST_PAV + NUM_ACC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_acc,
  input  logic [IDX_W-1:0]  cmd_src,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ST_W-1:0]   status_o
);
  localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_ACC);

  mac_op_e            op;
  sat_kind_e          kind;
  logic               is_sat, is_flags, is_move;
  logic [3:0]         mode_q, mode_d;
  logic [3:0]         sticky_q, sticky_d;     // {EV,N,Z,V}
  logic [NUM_ACC-1:0] pav_q, pav_d;
  logic [DATA_W-1:0]  acc_val, src_val, host_val;
  logic [DATA_W-1:0]  sat_res, acc_wdata;
  logic               sat_ovf, sat_v_any;
  logic               fz, fn, fv, fev;
  logic               stat_wr, host_acc_we;
  logic [ST_W-1:0]    base;
  logic [DATA_W-1:0]  rdata_q;

  assign op       = mac_op_e'(cmd_op);
  assign is_sat   = cmd_valid && (op == OP_SAT_S || op == OP_SAT_U || op == OP_SAT_F);
  assign is_flags = cmd_valid && (op == OP_FLAGS);
  assign is_move  = cmd_valid && (op == OP_MOVE);

  always_comb begin
    case (op)
      OP_SAT_S: kind = SK_SIGNED;
      OP_SAT_U: kind = SK_UNSIGNED;
      OP_SAT_F: kind = SK_FRAC;
      default:  kind = SK_NONE;
    endcase
  end

  assign stat_wr     = reg_we && (reg_sel == SEL_STAT);
  assign host_acc_we = reg_we && (reg_sel < SEL_STAT);

  mac_acc_bank #(.NUM_ACC(NUM_ACC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .cmd_we     (is_sat || is_move),
    .cmd_idx    (cmd_acc),
    .cmd_wdata  (acc_wdata),
    .host_we    (host_acc_we),
    .host_idx   (reg_sel[IDX_W-1:0]),
    .host_wdata (reg_wdata),
    .rd_a_idx   (cmd_acc),
    .rd_b_idx   (cmd_src),
    .rd_c_idx   (reg_sel[IDX_W-1:0]),
    .rd_a       (acc_val),
    .rd_b       (src_val),
    .rd_c       (host_val)
  );

  mac_sat_unit #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_sat (
    .val      (acc_val),
    .kind     (kind),
    .clamp_en (mode_q[ST_OMC]),
    .v_prev   (sticky_q[0]),
    .res      (sat_res),
    .ovf      (sat_ovf),
    .v_any    (sat_v_any)
  );

  mac_flag_eval #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_TOP(FRAC_TOP), .INT_TOP(INT_TOP)) u_flags (
    .val       (acc_val),
    .frac_mode (mode_q[ST_FRAC]),
    .sgn_mode  (mode_q[ST_SGN]),
    .pav       (pav_q[cmd_acc]),
    .z         (fz),
    .n         (fn),
    .v         (fv),
    .ev        (fev)
  );

  assign acc_wdata = is_move ? src_val : sat_res;

  // status base: a host write replaces the held word
  assign base   = stat_wr ? reg_wdata[ST_W-1:0] : {pav_q, sticky_q, mode_q};
  assign mode_d = base[3:0];

  always_comb begin
    sticky_d = base[7:4];
    if (is_sat)   sticky_d[0] = sticky_d[0] | sat_ovf;
    if (is_flags) sticky_d    = sticky_d | {fev, fn, fz, fv};
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_pav
    assign pav_d[i] = (is_move && cmd_acc == IDX_W'(i)) ? pav_q[cmd_src]
                    : (base[ST_PAV+i] | (is_sat && sat_v_any && cmd_acc == IDX_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      sticky_q <= '0;
      pav_q    <= '0;
      rdata_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      sticky_q <= sticky_d;
      pav_q    <= pav_d;
      rdata_q  <= (reg_sel < SEL_STAT) ? host_val
                : {{(DATA_W-ST_W){1'b0}}, pav_q, sticky_q, mode_q};
    end
  end

  assign reg_rdata = rdata_q;
  assign status_o  = {pav_q, sticky_q, mode_q};
endmodule

// File: rtl/mac_acc_sat_chk.sv
module mac_acc_sat_chk
  import mac_sat_pkg::*;
#(
  parameter int NUM_ACC = 4,
  parameter int IDX_W   = 2,
  parameter int SEL_W   = 3,
  parameter int ST_W    = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_acc,
  input logic [IDX_W-1:0] cmd_src,
  input logic             reg_we,
  input logic [SEL_W-1:0] reg_sel,
  input logic [ST_W-1:0]  status_o,
  input logic             is_sat,
  input logic             sat_ovf,
  input logic             sat_v_any
);
  logic st_write;
  assign st_write = reg_we && (reg_sel == SEL_W'(NUM_ACC));

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (status_o == '0));

  // R3
  p_sat_raises_v_r3: assert property (@(posedge clk) disable iff (rst)
    (is_sat && sat_ovf) |=> status_o[ST_V]);

  // R7
  p_sat_marks_acc_r7: assert property (@(posedge clk) disable iff (rst)
    (is_sat && sat_v_any) |=> status_o[ST_PAV + int'($past(cmd_acc))]);

  // R10
  p_move_copies_bit_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_MOVE) |=>
      (status_o[ST_PAV + int'($past(cmd_acc))] == $past(status_o[ST_PAV + int'(cmd_src)])));

  // R11
  p_v_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (status_o[ST_V] && !st_write) |=> status_o[ST_V]);
endmodule

bind mac_acc_sat mac_acc_sat_chk #(
  .NUM_ACC (NUM_ACC),
  .IDX_W   (IDX_W),
  .SEL_W   (SEL_W),
  .ST_W    (ST_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_acc   (cmd_acc),
  .cmd_src   (cmd_src),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .status_o  (status_o),
  .is_sat    (is_sat),
  .sat_ovf   (sat_ovf),
  .sat_v_any (sat_v_any)
);

// File: tb/sim_mac_acc_sat.sv
module sim_mac_acc_sat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_acc = '0;
  logic [1:0]  cmd_src = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [11:0] status_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [63:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  localparam logic [2:0] STAT = 3'd4;

  mac_acc_sat u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_acc(cmd_acc), .cmd_src(cmd_src), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_o(status_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares read results against the scoreboard queue
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      void'(due_q.pop_front());
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cmd(input logic [2:0] o, input logic [1:0] a, input logic [1:0] s);
    cmd_valid = 1'b1; cmd_op = o; cmd_acc = a; cmd_src = s;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cmd_wr(input logic [2:0] o, input logic [1:0] a,
                        input logic [2:0] sel, input logic [63:0] d);
    cmd_valid = 1'b1; cmd_op = o; cmd_acc = a; cmd_src = '0;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [63:0] e, input string t);
    reg_sel = sel;
    exp_q.push_back(e); due_q.push_back(cyc + 1); tag_q.push_back(t);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (status_o !== 12'h000) begin
      errors++; $display("FAIL R1 status_o: got %h expected %h", status_o, 12'h000);
    end
    rd(3'd0, 64'h0, "R1 acc0 after reset");
    rd(STAT, 64'h0, "R1 status after reset");

    // R2 host access
    wr(3'd1, 64'h0000_1234_5678_9abc);
    rd(3'd1, 64'h0000_1234_5678_9abc, "R2 acc1 readback");
    wr(STAT, 64'h2);
    rd(STAT, 64'h002, "R2 status readback");

    // R3 signed, in range and overflow without clamp
    cmd(3'd0, 2'd1, 2'd0);
    rd(3'd1, 64'h0000_1234_5678_9abc, "R3 in-range unchanged");
    rd(STAT, 64'h002, "R3 no flag on in-range");
    wr(3'd2, 64'h0001_8000_0000_0000);
    cmd(3'd0, 2'd2, 2'd0);
    rd(3'd2, 64'hffff_8000_0000_0000, "R3 sign extended");
    rd(STAT, 64'h412, "R3 R7 V and acc2 bit");

    // R4 signed clamp; R11 status write clears
    wr(STAT, 64'h0A);
    rd(STAT, 64'h00A, "R11 write replaces flags");
    wr(3'd3, 64'h0002_0000_0000_0001);
    cmd(3'd0, 2'd3, 2'd0);
    rd(3'd3, 64'h0000_0000_7fff_ffff, "R4 positive clamp");
    rd(STAT, 64'h81A, "R4 status");
    wr(3'd0, 64'h7000_8000_0000_0000);
    cmd(3'd0, 2'd0, 2'd0);
    rd(3'd0, 64'hffff_ffff_8000_0000, "R4 negative clamp");
    rd(STAT, 64'h91A, "R4 status acc0 bit");

    // R7 sticky V forces clamp of in-range value
    cmd(3'd0, 2'd1, 2'd0);
    rd(3'd1, 64'h0000_0000_7fff_ffff, "R7 clamp from held V");
    rd(STAT, 64'hB1A, "R7 acc1 bit");

    // R5 unsigned
    wr(STAT, 64'h08);
    wr(3'd2, 64'h0040_0000_0000_0000);
    cmd(3'd1, 2'd2, 2'd0);
    rd(3'd2, 64'h0, "R5 above 2^53 clamps to zero");
    rd(STAT, 64'h418, "R5 status");
    wr(3'd3, 64'h0001_0000_0000_0005);
    cmd(3'd1, 2'd3, 2'd0);
    rd(3'd3, 64'h0000_ffff_ffff_ffff, "R5 clamp to max");
    rd(STAT, 64'hC18, "R5 status acc3");
    wr(STAT, 64'h0);
    wr(3'd1, 64'h00ff_1234_5678_9abc);
    cmd(3'd1, 2'd1, 2'd0);
    rd(3'd1, 64'h0000_1234_5678_9abc, "R5 masked");
    rd(STAT, 64'h210, "R5 masked status");

    // R6 fractional
    wr(STAT, 64'h0C);
    wr(3'd0, 64'hfff0_0000_0000_0000);
    cmd(3'd2, 2'd0, 2'd0);
    rd(3'd0, 64'h0000_7fff_ffff_ffff, "R6 positive clamp");
    rd(STAT, 64'h11C, "R6 status");
    wr(3'd1, 64'h0001_9000_0000_0000);
    cmd(3'd2, 2'd1, 2'd0);
    rd(3'd1, 64'hffff_8000_0000_0000, "R6 negative clamp");
    rd(STAT, 64'h31C, "R6 status acc1");

    // R8 R9 flag update
    wr(STAT, 64'h0);
    wr(3'd2, 64'h0);
    cmd(3'd3, 2'd2, 2'd0);
    rd(STAT, 64'h020, "R8 zero flag");
    rd(3'd2, 64'h0, "R8 accumulator untouched");
    wr(3'd3, 64'h0000_8000_0000_0001);
    cmd(3'd3, 2'd3, 2'd0);
    rd(STAT, 64'h0E0, "R8 R9 N and unsigned EV");
    wr(STAT, 64'h400);
    cmd(3'd3, 2'd2, 2'd0);
    rd(STAT, 64'h430, "R8 V from acc bit");
    wr(STAT, 64'h2);
    wr(3'd1, 64'h0000_0000_8000_0000);
    cmd(3'd3, 2'd1, 2'd0);
    rd(STAT, 64'h002, "R9 signed no EV");
    wr(3'd1, 64'hffff_ffff_0000_0000);
    cmd(3'd3, 2'd1, 2'd0);
    rd(STAT, 64'h042, "R9 signed sign ext N");
    wr(STAT, 64'h4);
    wr(3'd1, 64'h0000_00ff_0000_0000);
    cmd(3'd3, 2'd1, 2'd0);
    rd(STAT, 64'h004, "R9 fractional no EV");
    wr(STAT, 64'h2);
    cmd(3'd3, 2'd1, 2'd0);
    rd(STAT, 64'h082, "R9 signed EV");

    // R10 move
    wr(STAT, 64'h100);
    wr(3'd0, 64'habcd);
    cmd(3'd4, 2'd3, 2'd0);
    rd(3'd3, 64'habcd, "R10 value copied");
    rd(STAT, 64'h900, "R10 bit copied");
    cmd(3'd4, 2'd0, 2'd1);
    rd(3'd0, 64'h0000_00ff_0000_0000, "R10 second copy");
    rd(STAT, 64'h800, "R10 bit cleared by copy");

    // R12 same-cycle collisions
    wr(STAT, 64'h0);
    wr(3'd2, 64'h0100_0000_0000_0001);
    cmd_wr(3'd1, 2'd2, 3'd2, 64'h55);
    rd(3'd2, 64'h1, "R12 command wins accumulator");
    rd(STAT, 64'h410, "R12 status after clash");
    cmd_wr(3'd3, 2'd1, STAT, 64'h4);
    rd(STAT, 64'h084, "R12 old mode flags merged");

    repeat (3) @(negedge clk);
    checks++;
    if (due_q.size() != 0) begin
      errors++; $display("FAIL scoreboard: got %0d pending expected 0", due_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule